// File: doc/BRIEF.md
# Asynchronous NAND Bus Strobe Sequencer

This block turns single-byte host accesses into correctly timed cycles on an asynchronous, byte-wide NAND flash bus. The host presents a request with an address made of a chip-select index and an offset inside that chip's window. The offset chooses a command-latch write, an address-latch write, or a data transfer, and the flag `req_write` gives the direction. The block then runs the chip enable, the command and address latch enables, the write strobe and the read strobe through a fixed order of phases. The length of each phase comes from a byte field of one of two 32-bit timing words.

A write cycle has four phases in order: an access delay after chip enable, the write-strobe low pulse, the write-strobe high time, and a wait that covers the delay from the strobe rising to the device going busy. A read cycle has the same access delay, then the read-strobe low pulse, the read-strobe high hold and a bus-release gap. Read data is captured a programmed number of clocks after the read strobe falls. The device's ready/busy pin is synchronised and reported in bit 31 of a status word. That bit is forced low during the post-write wait, so software never sees a ready flag that predates the device going busy.

Top module: `nand_bus_timer`

## Requirements
- R1: Offset 0 of a window starts a command write cycle with CLE high for the whole cycle. Offset 4 starts an address write cycle with ALE high. Offset 8 starts a data cycle with both latch enables low, and it may be a write or a read. Every other offset, and any read at offset 0 or 4, starts no cycle and leaves `busy` low.
- R2: While a cycle runs, only the chip-enable line selected by address bits [9:8] is low, and it stays low for the whole cycle. While the block is idle, all chip-enable lines are high.
- R3: A write cycle lasts `timing_wr[31:24]` clocks of access delay, then `timing_wr[15:8]` minus `timing_wr[7:0]` clocks with WE# low, then `timing_wr[7:0]` clocks with WE# high, then `timing_wr[23:16]` clocks of post-write wait. The write byte is driven onto the bus for every clock of the cycle.
- R4: A read cycle lasts `timing_wr[31:24]` clocks of access delay, then `timing_rd[15:8]` clocks with RE# low, then `timing_rd[23:16]` clocks of RE# high hold, then `timing_rd[7:0]` clocks of bus release. The data bus is never driven during a read.
- R5: Read data is sampled on the clock edge `timing_rd[31:24]` clocks after the edge that drives RE# low. If the cycle ends before that edge, the sample is taken on the final edge of the cycle. `rd_valid` is high for the one clock that follows the sample.
- R6: A tick field of zero counts as one clock. If `timing_wr[15:8]` is not greater than `timing_wr[7:0]`, the WE# low pulse lasts one clock.
- R7: `busy` is high from the clock after a request is accepted until the cycle ends. A request is accepted on an edge where `req_valid` is high and `busy` is low. A request held through a busy period is accepted after the running cycle ends, so bytes reach the bus in the order they were issued.
- R8: `status[31]` follows the ready/busy pin (high means ready) through a two-flop synchroniser. `status[30:0]` always reads zero.
- R9: During the post-write wait, `status[31]` reads low whatever the level of the ready/busy pin.
- R10: Both timing words are sampled when a request is accepted. Changing them during a cycle has no effect on that cycle.
- R11: After reset the block is idle. In that state `busy` is low, CE# lines, WE# and RE# are high, CLE, ALE and the data-bus enable are low, and `status` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timing_wr | input | 32 | Access delay, post-write wait, write cycle, write-strobe high width (MSB to LSB bytes) |
| timing_rd | input | 32 | Sample delay, RE# high hold, RE# low width, bus release (MSB to LSB bytes) |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 10 | Chip-select index [9:8] and window offset [7:0] |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Cycle in progress; requests wait while high |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-clock pulse after a read byte is captured |
| status | output | 32 | Bit 31 ready flag, other bits zero |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus input value |
| nand_rb | input | 1 | Ready/busy pin, high = ready |

## Verification
Some properties are checked by assertions on every cycle. These are the mutual exclusion of the strobes and of the latch enables, the single active chip enable held steady through a cycle, the quiet bus while idle, the absence of drive during reads, the ready bit's two-cycle lag behind the pin, and the acceptance of a command write or the rejection of an undecoded offset. Other behaviours can only be shown by the bench's scenarios, because each depends on a count across a whole cycle or on a sequence of cycles. These are the exact phase lengths for a given pair of timing words, the zero-as-one and short-pulse rules, the sample point of read data against a changing bus, the masking of the ready flag during the post-write wait, the ordering of a request held while busy, and the immunity to timing words changed mid-cycle.

// File: rtl/nbt_pkg.sv
package nbt_pkg;

    localparam int FIELD_W  = 8;
    localparam int BYTE_W   = 8;
    localparam int OFS_CMD  = 0;
    localparam int OFS_ADDR = 4;
    localparam int OFS_DATA = 8;

    typedef logic [FIELD_W-1:0] tick_t;

    // Write timing word, most significant byte first.
    typedef struct packed {
        tick_t ce_dly;
        tick_t post_wait;
        tick_t cyc;
        tick_t hi;
    } wr_tim_t;

    // Read timing word, most significant byte first.
    typedef struct packed {
        tick_t sample;
        tick_t hold;
        tick_t low;
        tick_t release_gap;
    } rd_tim_t;

    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_DATA = 2'd2,
        K_NONE = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_WLOW  = 3'd2,
        PH_WHIGH = 3'd3,
        PH_WAIT  = 3'd4,
        PH_RLOW  = 3'd5,
        PH_RHOLD = 3'd6,
        PH_RREL  = 3'd7
    } phase_e;

    // Counter preload for a phase of f clocks; zero counts as one clock.
    function automatic tick_t load_of(tick_t f);
        return (f == '0) ? '0 : f - tick_t'(1);
    endfunction

    // Preload for the write-strobe low pulse: cycle minus high width, at least one.
    function automatic tick_t wlow_load(tick_t cyc, tick_t hi);
        return (cyc > hi) ? (cyc - hi - tick_t'(1)) : '0;
    endfunction

endpackage

// File: rtl/nbt_decode.sv
module nbt_decode
    import nbt_pkg::*;
#(
    parameter int WIN_BITS = 8
) (
    input  logic                req_write,
    input  logic [WIN_BITS-1:0] ofs,
    output kind_e               kind,
    output logic                hit
);

    always_comb begin
        kind = K_NONE;
        if (ofs == WIN_BITS'(OFS_CMD) && req_write) begin
            kind = K_CMD;
        end else if (ofs == WIN_BITS'(OFS_ADDR) && req_write) begin
            kind = K_ADDR;
        end else if (ofs == WIN_BITS'(OFS_DATA)) begin
            kind = K_DATA;
        end
        hit = (kind != K_NONE);
    end

endmodule

// File: rtl/nbt_seq.sv
module nbt_seq
    import nbt_pkg::*;
#(
    parameter int CS_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              start_wr,
    input  kind_e             start_kind,
    input  logic [CS_W-1:0]   start_cs,
    input  logic [BYTE_W-1:0] start_data,
    input  wr_tim_t           wt_in,
    input  rd_tim_t           rt_in,
    output phase_e            phase,
    output logic              cur_wr,
    output kind_e             cur_kind,
    output logic [CS_W-1:0]   cur_cs,
    output logic [BYTE_W-1:0] cur_data,
    output rd_tim_t           rt,
    output logic              rlow_enter,
    output logic              read_end
);

    tick_t   cnt;
    wr_tim_t wt;
    logic    phase_done;

    assign phase_done = (cnt == '0);
    assign rlow_enter = (phase == PH_SETUP) && phase_done && !cur_wr;
    assign read_end   = (phase == PH_RREL) && phase_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            cnt      <= '0;
            cur_wr   <= 1'b0;
            cur_kind <= K_NONE;
            cur_cs   <= '0;
            cur_data <= '0;
            wt       <= '0;
            rt       <= '0;
        end else if (phase == PH_IDLE) begin
            if (start) begin
                phase    <= PH_SETUP;
                cnt      <= load_of(wt_in.ce_dly);
                cur_wr   <= start_wr;
                cur_kind <= start_kind;
                cur_cs   <= start_cs;
                cur_data <= start_data;
                wt       <= wt_in;
                rt       <= rt_in;
            end
        end else if (!phase_done) begin
            cnt <= cnt - tick_t'(1);
        end else begin
            unique case (phase)
                PH_SETUP: begin
                    if (cur_wr) begin
                        phase <= PH_WLOW;
                        cnt   <= wlow_load(wt.cyc, wt.hi);
                    end else begin
                        phase <= PH_RLOW;
                        cnt   <= load_of(rt.low);
                    end
                end
                PH_WLOW: begin
                    phase <= PH_WHIGH;
                    cnt   <= load_of(wt.hi);
                end
                PH_WHIGH: begin
                    phase <= PH_WAIT;
                    cnt   <= load_of(wt.post_wait);
                end
                PH_RLOW: begin
                    phase <= PH_RHOLD;
                    cnt   <= load_of(rt.hold);
                end
                PH_RHOLD: begin
                    phase <= PH_RREL;
                    cnt   <= load_of(rt.release_gap);
                end
                default: begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/nbt_capture.sv
module nbt_capture
    import nbt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  tick_t             delay,
    input  logic              fin,
    input  logic [BYTE_W-1:0] dq_in,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_valid
);

    logic  armed;
    tick_t acnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed    <= 1'b0;
            acnt     <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (arm) begin
                armed <= 1'b1;
                acnt  <= load_of(delay);
            end else if (armed) begin
                if (acnt == '0 || fin) begin
                    rd_data  <= dq_in;
                    rd_valid <= 1'b1;
                    armed    <= 1'b0;
                end else begin
                    acnt <= acnt - tick_t'(1);
                end
            end
        end
    end

endmodule

// File: rtl/nbt_ready.sv
module nbt_ready (
    input  logic clk,
    input  logic rst,
    input  logic rb,
    input  logic mask,
    output logic ready
);

    logic s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= rb;
            s2 <= s1;
        end
    end

    assign ready = s2 && !mask;

endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
    import nbt_pkg::*;
#(
    parameter int CS_NUM   = 4,
    parameter int WIN_BITS = 8
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [31:0]                        timing_wr,
    input  logic [31:0]                        timing_rd,
    input  logic                               req_valid,
    input  logic                               req_write,
    input  logic [$clog2(CS_NUM)+WIN_BITS-1:0] req_addr,
    input  logic [BYTE_W-1:0]                  req_wdata,
    output logic                               busy,
    output logic [BYTE_W-1:0]                  rd_data,
    output logic                               rd_valid,
    output logic [31:0]                        status,
    output logic [CS_NUM-1:0]                  nand_ce_n,
    output logic                               nand_cle,
    output logic                               nand_ale,
    output logic                               nand_we_n,
    output logic                               nand_re_n,
    output logic [BYTE_W-1:0]                  nand_dq_out,
    output logic                               nand_dq_oe,
    input  logic [BYTE_W-1:0]                  nand_dq_in,
    input  logic                               nand_rb
);

    localparam int CS_W   = $clog2(CS_NUM);
    localparam int ADDR_W = CS_W + WIN_BITS;

    kind_e             req_kind;
    logic              req_hit;
    logic              start;
    phase_e            phase;
    logic              cur_wr;
    kind_e             cur_kind;
    logic [CS_W-1:0]   cur_cs;
    logic [BYTE_W-1:0] cur_data;
    rd_tim_t           rt;
    logic              rlow_enter;
    logic              read_end;
    logic              ready;

    nbt_decode #(.WIN_BITS(WIN_BITS)) u_decode (
        .req_write (req_write),
        .ofs       (req_addr[WIN_BITS-1:0]),
        .kind      (req_kind),
        .hit       (req_hit)
    );

    assign start = req_valid && req_hit && !busy;

    nbt_seq #(.CS_W(CS_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_wr   (req_write),
        .start_kind (req_kind),
        .start_cs   (req_addr[ADDR_W-1:WIN_BITS]),
        .start_data (req_wdata),
        .wt_in      (wr_tim_t'(timing_wr)),
        .rt_in      (rd_tim_t'(timing_rd)),
        .phase      (phase),
        .cur_wr     (cur_wr),
        .cur_kind   (cur_kind),
        .cur_cs     (cur_cs),
        .cur_data   (cur_data),
        .rt         (rt),
        .rlow_enter (rlow_enter),
        .read_end   (read_end)
    );

    nbt_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .arm      (rlow_enter),
        .delay    (rt.sample),
        .fin      (read_end),
        .dq_in    (nand_dq_in),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    nbt_ready u_ready (
        .clk   (clk),
        .rst   (rst),
        .rb    (nand_rb),
        .mask  (phase == PH_WAIT),
        .ready (ready)
    );

    assign busy        = (phase != PH_IDLE);
    assign nand_ce_n   = busy ? ~(CS_NUM'(1) << cur_cs) : '1;
    assign nand_cle    = busy && cur_wr && (cur_kind == K_CMD);
    assign nand_ale    = busy && cur_wr && (cur_kind == K_ADDR);
    assign nand_we_n   = (phase != PH_WLOW);
    assign nand_re_n   = (phase != PH_RLOW);
    assign nand_dq_oe  = busy && cur_wr;
    assign nand_dq_out = cur_data;
    assign status      = {ready, 31'd0};

endmodule

// File: rtl/nbt_checker.sv
module nbt_checker #(
    parameter int CS_NUM   = 4,
    parameter int WIN_BITS = 8
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               req_valid,
    input logic                               req_write,
    input logic [$clog2(CS_NUM)+WIN_BITS-1:0] req_addr,
    input logic                               busy,
    input logic                               rd_valid,
    input logic [31:0]                        status,
    input logic [CS_NUM-1:0]                  nand_ce_n,
    input logic                               nand_cle,
    input logic                               nand_ale,
    input logic                               nand_we_n,
    input logic                               nand_re_n,
    input logic [7:0]                         nand_dq_out,
    input logic                               nand_dq_oe,
    input logic                               nand_rb
);

    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale)); // R1
    AST_CMD_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_write && req_addr[WIN_BITS-1:0] == '0) |=> (busy && nand_cle)); // R1
    AST_ODD_OFS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_addr[WIN_BITS-1:0] == WIN_BITS'(1)) |=> !busy); // R1
    AST_CE_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~nand_ce_n) <= 1); // R2
    AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> (busy && nand_ce_n != '1)); // R2
    AST_CE_STEADY: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(nand_ce_n)); // R2
    AST_DQ_STEADY: assert property (@(posedge clk) disable iff (rst)
        (nand_dq_oe && $past(nand_dq_oe)) |-> $stable(nand_dq_out)); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n)); // R4
    AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe); // R4
    AST_RDV_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(busy) && !$past(nand_dq_oe))); // R5
    AST_RDY_LAG: assert property (@(posedge clk) disable iff (rst)
        status[31] |-> $past(nand_rb, 2)); // R8
    AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[30:0] == '0); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (nand_ce_n == '1 && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !nand_dq_oe)); // R11

endmodule

bind nand_bus_timer nbt_checker #(.CS_NUM(CS_NUM), .WIN_BITS(WIN_BITS)) u_nbt_checker (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .busy        (busy),
    .rd_valid    (rd_valid),
    .status      (status),
    .nand_ce_n   (nand_ce_n),
    .nand_cle    (nand_cle),
    .nand_ale    (nand_ale),
    .nand_we_n   (nand_we_n),
    .nand_re_n   (nand_re_n),
    .nand_dq_out (nand_dq_out),
    .nand_dq_oe  (nand_dq_oe),
    .nand_rb     (nand_rb)
);

// File: tb/nand_bus_timer_bench.sv
`timescale 1ns/1ps
module nand_bus_timer_bench;

    localparam logic [7:0] BASE = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] timing_wr = '0;
    logic [31:0] timing_rd = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [31:0] status;
    logic [3:0]  nand_ce_n;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = '0;
    logic        nand_rb = 1'b1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    nand_bus_timer u_nand_bus_timer (
        .clk(clk), .rst(rst), .timing_wr(timing_wr), .timing_rd(timing_rd),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
        .status(status), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    // Bus monitor: free-running counters sampled at falling edges.
    int m_busy = 0, m_pre = 0, m_we = 0, m_re = 0, m_nrdy = 0, m_oe = 0, m_ceb = 0, m_rdv = 0;
    int log_n = 0;
    logic [9:0] log_v [32];
    logic seen = 1'b0;
    logic prev_we = 1'b1, prev_re = 1'b1;
    int j = 0;
    int exp_cs = 0;

    always @(negedge clk) begin
        if (busy) begin
            m_busy++;
            if (!nand_we_n) m_we++;
            if (!nand_re_n) m_re++;
            if (!nand_we_n || !nand_re_n) seen = 1'b1;
            if (!seen) m_pre++;
            if (!status[31]) m_nrdy++;
            if (nand_dq_oe) m_oe++;
            if (nand_ce_n != ~(4'(1) << exp_cs)) m_ceb++;
        end else begin
            seen = 1'b0;
        end
        if (rd_valid) m_rdv++;
        if (!prev_we && nand_we_n && log_n < 32) begin
            log_v[log_n] = {nand_cle, nand_ale, nand_dq_out};
            log_n++;
        end
        if (prev_re && !nand_re_n) j = 1;
        else if (j > 0 && busy) j++;
        else j = 0;
        nand_dq_in = BASE + 8'(j);
        prev_we = nand_we_n;
        prev_re = nand_re_n;
    end

    int s_busy, s_pre, s_we, s_re, s_nrdy, s_oe, s_ceb, s_rdv, s_log;

    task automatic snap();
        s_busy = m_busy; s_pre = m_pre; s_we = m_we; s_re = m_re;
        s_nrdy = m_nrdy; s_oe = m_oe; s_ceb = m_ceb; s_rdv = m_rdv; s_log = log_n;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic wr, input int cs, input int ofs, input logic [7:0] d);
        @(negedge clk);
        while (busy) @(negedge clk);
        exp_cs    = cs;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {2'(cs), 8'(ofs)};
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R11 busy in reset", int'(busy), 0);
        chk("R11 ce_n in reset", int'(nand_ce_n), 15);
        chk("R11 strobes in reset", int'({nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe}), 24);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 status after reset", int'(status), 0);
        repeat (3) @(negedge clk);
        chk("R8 status ready idle", int'(status == 32'h8000_0000), 1);
    endtask

    task automatic t_cmd_write();
        timing_wr = {8'd3, 8'd4, 8'd7, 8'd2};
        snap();
        issue(1'b1, 2, 0, 8'hA5);
        wait_idle();
        chk("R3 write busy clocks", m_busy - s_busy, 14);
        chk("R3 access delay", m_pre - s_pre, 3);
        chk("R3 WE low clocks", m_we - s_we, 5);
        chk("R3 data driven clocks", m_oe - s_oe, 14);
        chk("R9 ready masked clocks", m_nrdy - s_nrdy, 4);
        chk("R2 chip enable select", m_ceb - s_ceb, 0);
        chk("R1 command byte log count", log_n - s_log, 1);
        chk("R1 command latch byte", int'(log_v[s_log]), int'({2'b10, 8'hA5}));
    endtask

    task automatic t_addr_stall();
        timing_wr = {8'd1, 8'd1, 8'd3, 8'd1};
        snap();
        issue(1'b1, 1, 4, 8'h11);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = {2'd1, 8'd4};
        req_wdata = 8'h22;
        @(negedge clk);
        chk("R7 held request waits", log_n - s_log, 0);
        while (busy) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        chk("R7 two cycles busy clocks", m_busy - s_busy, 10);
        chk("R7 bytes logged", log_n - s_log, 2);
        chk("R7 first address byte", int'(log_v[s_log]), int'({2'b01, 8'h11}));
        chk("R7 second address byte", int'(log_v[s_log+1]), int'({2'b01, 8'h22}));
        chk("R2 chip enable cs1", m_ceb - s_ceb, 0);
    endtask

    task automatic t_read();
        timing_wr = {8'd2, 8'd0, 8'd0, 8'd0};
        timing_rd = {8'd3, 8'd2, 8'd4, 8'd3};
        snap();
        issue(1'b0, 3, 8, 8'h00);
        wait_idle();
        @(negedge clk);
        chk("R4 read busy clocks", m_busy - s_busy, 11);
        chk("R4 RE low clocks", m_re - s_re, 4);
        chk("R4 no drive on read", m_oe - s_oe, 0);
        chk("R5 sampled byte", int'(rd_data), int'(BASE + 8'd3));
        chk("R5 rd_valid pulses", m_rdv - s_rdv, 1);
        chk("R2 chip enable cs3", m_ceb - s_ceb, 0);
    endtask

    task automatic t_read_late();
        timing_wr = {8'd1, 8'd0, 8'd0, 8'd0};
        timing_rd = {8'd20, 8'd1, 8'd2, 8'd1};
        snap();
        issue(1'b0, 0, 8, 8'h00);
        wait_idle();
        @(negedge clk);
        chk("R5 late sample at cycle end", int'(rd_data), int'(BASE + 8'd4));
        chk("R4 short read busy", m_busy - s_busy, 5);
    endtask

    task automatic t_zero();
        timing_wr = '0;
        snap();
        issue(1'b1, 0, 8, 8'h3C);
        wait_idle();
        chk("R6 zero fields busy", m_busy - s_busy, 4);
        chk("R6 zero fields WE low", m_we - s_we, 1);
        chk("R1 data write latch enables", int'(log_v[s_log]), int'({2'b00, 8'h3C}));
    endtask

    task automatic t_short_we();
        timing_wr = {8'd1, 8'd1, 8'd2, 8'd5};
        snap();
        issue(1'b1, 1, 0, 8'h90);
        wait_idle();
        chk("R6 short WE low", m_we - s_we, 1);
        chk("R6 short WE busy", m_busy - s_busy, 8);
    endtask

    task automatic t_ignore();
        snap();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = {2'd0, 8'd1}; req_wdata = 8'h77;
        repeat (3) @(negedge clk);
        req_write = 1'b0; req_addr = {2'd0, 8'd0};
        repeat (3) @(negedge clk);
        req_addr = {2'd0, 8'd4};
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R1 ignored offsets busy", m_busy - s_busy, 0);
        chk("R1 ignored offsets bus", log_n - s_log, 0);
    endtask

    task automatic t_tim_change();
        timing_wr = {8'd2, 8'd2, 8'd6, 8'd2};
        snap();
        issue(1'b1, 2, 4, 8'h5A);
        timing_wr = {8'd9, 8'd9, 8'd9, 8'd1};
        wait_idle();
        chk("R10 busy with changed word", m_busy - s_busy, 10);
        chk("R10 WE low with changed word", m_we - s_we, 4);
    endtask

    task automatic t_ready();
        nand_rb = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 not ready", int'(status), 0);
        nand_rb = 1'b1;
        @(negedge clk);
        chk("R8 sync lag", int'(status), 0);
        repeat (2) @(negedge clk);
        chk("R8 ready again", int'(status == 32'h8000_0000), 1);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_cmd_write();
        t_addr_stall();
        t_read();
        t_read_late();
        t_zero();
        t_short_we();
        t_ignore();
        t_tim_change();
        t_ready();
        finish_run();
    end

endmodule